// File: doc/BRIEF.md
# Memory Port Write Sequencer

This block sits between a user write source and the native write port of a multi-port memory controller. The user hands it one command at a time (start address, transfer size code, number of data beats) and streams the data beats after it. The sequencer turns each command into a correctly ordered exchange with the controller. For bursts it fills the controller's write FIFO first and then raises the address request. For single-doubleword writes, which cover byte, half-word, word and doubleword, it raises the request first and pushes the data only after the acknowledge.

Burst requests always carry an address aligned to the burst size. When the user's start address sits inside the burst, the sequencer pushes pad beats with all byte enables low in front of the user data. It also pads after the user data up to the full burst length, so pad beats are never committed to memory.

Two flow-control modes are supported. In budget mode the controller offers no almost-full flag. The sequencer counts the bytes it has queued and refuses a command that would exceed the budget, then waits for the FIFO empty flag, clears the count and carries on. In almost-full mode, pushing pauses while the controller's almost-full flag is high.

Top module: `wseq_top`

## Requirements
- R1: For a burst (size code 1 to 5), every beat of that burst is pushed before the address request is raised, and no push ever happens in a cycle where the address request is high.
- R2: For a single-doubleword write (size code 0), the address request is raised first. The one data push happens at least one cycle after the cycle in which the acknowledge is seen, and it carries the user's byte enables unchanged.
- R3: Only one request is outstanding at a time. A single-doubleword request is raised only after every push belonging to earlier commands has been made.
- R4: Once raised, the address request stays high, with address and size code stable, until the acknowledge is seen.
- R5: Size code 0 means one 8-byte beat, and size code k (1..5) means 2^k beats of 8 bytes. The request address is the command address with its low log2(8 x beats) bits cleared, and the size output repeats the command's size code.
- R6: A burst pushes exactly 2^k beats. There are L leading pad beats, where L is bits [k+2:3] of the command address, and each pad has byte enables 8'h00. The command's beats follow, then trailing pad beats (byte enables 8'h00) fill the burst.
- R7: In budget mode (afMode=0), a command is not accepted while the queued bytes plus the command's bytes (8 x beats) would exceed 1024. The sequencer then makes no push and waits for the empty flag. Once the flag is seen, the count is cleared and the command is accepted.
- R8: In almost-full mode (afMode=1), no push is made while wrAlmostFull is high, and the byte budget does not block acceptance.
- R9: After reset the address request and push are low and a command can be accepted.
- R10: User data beats reach the write FIFO in their input order without loss or duplication, each with its own byte enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| afMode | input | 1 | 1 selects almost-full flow control, 0 selects byte-budget flow control |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command accepted when high together with cmdValid |
| cmdAddr | input | 32 | Byte start address of the command |
| cmdSize | input | 3 | Transfer size code (0 single doubleword, k = 2^k beats) |
| cmdLen | input | 6 | Number of user data beats for a burst |
| dataValid | input | 1 | User data beat offered |
| dataReady | output | 1 | User data beat taken |
| dataIn | input | 64 | User data beat |
| dataBe | input | 8 | User byte enables for the beat |
| wrPush | output | 1 | Push into the controller write FIFO |
| wrData | output | 64 | Write FIFO data |
| wrBe | output | 8 | Write FIFO byte enables (zero for pad beats) |
| wrEmpty | input | 1 | Controller write FIFO empty |
| wrAlmostFull | input | 1 | Controller write FIFO almost full |
| addrReq | output | 1 | Address request to the controller |
| addrOut | output | 32 | Request address, aligned to the transfer size |
| sizeOut | output | 3 | Request size code |
| addrAck | input | 1 | Address acknowledge from the controller |

## Verification
A beat counter or phase register that slips shows up at once as a wrong pad/data pattern on wrBe, or as a push count other than 2^k before addrReq rises, within the burst it corrupts. A byte counter that is not cleared, or clears too early, shows up as a command held off for good, or accepted without the empty flag, at the next command that crosses the budget. An ordering fault in the single-write path is visible in the same transaction as a push sitting in or before the acknowledge cycle.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

  localparam int SIZE_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_SMALL_REQ,
    ST_SMALL_PUSH,
    ST_FILL,
    ST_BURST_REQ
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;
    logic pushPad;
    logic pushUser;
    logic clrBytes;
  } seqStrobes_t;

  // status from datapath to control
  typedef struct packed {
    logic inUser;
    logic lastBeat;
    logic budgetOk;
  } seqStatus_t;

endpackage

// File: rtl/wseq_datapath.sv
module wseq_datapath
  import wseq_pkg::*;
#(
  parameter int AddrW       = 32,
  parameter int DataW       = 64,
  parameter int MaxSizeLog  = 5,
  parameter int BudgetBytes = 1024,
  localparam int BeatW      = MaxSizeLog + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                afMode,
  input  seqStrobes_t         stb,
  input  logic [AddrW-1:0]    cmdAddr,
  input  logic [SIZE_W-1:0]   cmdSize,
  input  logic [BeatW-1:0]    cmdLen,
  input  logic [DataW-1:0]    dataIn,
  input  logic [DataW/8-1:0]  dataBe,
  input  logic                addrReq,
  output seqStatus_t          status,
  output logic [DataW-1:0]    wrData,
  output logic [DataW/8-1:0]  wrBe,
  output logic [AddrW-1:0]    addrOut,
  output logic [SIZE_W-1:0]   sizeOut
);

  localparam int BeW  = DataW / 8;
  localparam int OffW = $clog2(BeW);
  localparam int CntW = $clog2(BudgetBytes + 1) + 1;

  function automatic logic [SIZE_W-1:0] clampSize(input logic [SIZE_W-1:0] sz);
    return (sz > SIZE_W'(MaxSizeLog)) ? SIZE_W'(MaxSizeLog) : sz;
  endfunction

  function automatic logic [BeatW-1:0] beatsOf(input logic [SIZE_W-1:0] sz);
    return BeatW'(1) << clampSize(sz);
  endfunction

  // command decode
  logic [BeatW-1:0] cmdBeats;
  logic [AddrW-1:0] spanMask;
  logic [BeatW-1:0] leadIn;
  logic [BeatW:0]   endSum;
  logic [BeatW-1:0] endIn;
  logic [CntW-1:0]  needBytes;

  always_comb begin
    cmdBeats  = beatsOf(cmdSize);
    spanMask  = (AddrW'(cmdBeats) << OffW) - AddrW'(1);
    leadIn    = BeatW'(cmdAddr >> OffW) & (cmdBeats - BeatW'(1));
    endSum    = {1'b0, leadIn} + {1'b0, cmdLen};
    endIn     = (endSum > {1'b0, cmdBeats}) ? cmdBeats : endSum[BeatW-1:0];
    needBytes = CntW'(cmdBeats) << OffW;
  end

  // registered command
  logic [AddrW-1:0]  addrReg;
  logic [SIZE_W-1:0] sizeReg;
  logic [BeatW-1:0]  leadReg;
  logic [BeatW-1:0]  endReg;
  logic [BeatW-1:0]  lastReg;
  logic [BeatW-1:0]  beatIdx;
  logic [CntW-1:0]   queued;

  wire anyPush = stb.pushPad | stb.pushUser;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      sizeReg <= '0;
      leadReg <= '0;
      endReg  <= '0;
      lastReg <= '0;
      beatIdx <= '0;
    end else if (stb.loadCmd) begin
      addrReg <= cmdAddr & ~spanMask;
      sizeReg <= clampSize(cmdSize);
      leadReg <= leadIn;
      endReg  <= endIn;
      lastReg <= cmdBeats - BeatW'(1);
      beatIdx <= '0;
    end else if (anyPush) begin
      beatIdx <= beatIdx + BeatW'(1);
    end
  end

  // queued byte counter for budget mode
  always_ff @(posedge clk) begin
    if (!rstN)                  queued <= '0;
    else if (stb.clrBytes)      queued <= '0;
    else if (anyPush && !afMode) queued <= queued + CntW'(BeW);
  end

  always_comb begin
    status.inUser   = (beatIdx >= leadReg) && (beatIdx < endReg);
    status.lastBeat = (beatIdx == lastReg);
    status.budgetOk = ({1'b0, queued} + {1'b0, needBytes}) <= (CntW + 1)'(BudgetBytes);
  end

  assign wrData  = stb.pushUser ? dataIn : '0;
  assign wrBe    = stb.pushUser ? dataBe : '0;
  assign addrOut = addrReg;
  assign sizeOut = sizeReg;

  AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (!rstN)
    !afMode |-> queued <= CntW'(BudgetBytes)); // R7

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    addrReq |-> (addrOut & ((AddrW'(beatsOf(sizeOut)) << OffW) - AddrW'(1))) == '0); // R5

endmodule

// File: rtl/wseq_control.sv
module wseq_control
  import wseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              afMode,
  input  logic              cmdValid,
  input  logic [SIZE_W-1:0] cmdSize,
  input  logic              dataValid,
  input  logic              wrAlmostFull,
  input  logic              wrEmpty,
  input  logic              addrAck,
  input  seqStatus_t        status,
  output seqStrobes_t       stb,
  output logic              cmdReady,
  output logic              dataReady,
  output logic              wrPush,
  output logic              addrReq
);

  seqState_t state, nextState;
  logic afStall;

  always_comb begin
    stb       = '0;
    cmdReady  = 1'b0;
    dataReady = 1'b0;
    addrReq   = 1'b0;
    nextState = state;
    afStall   = afMode && wrAlmostFull;
    unique case (state)
      ST_IDLE: begin
        cmdReady = afMode || status.budgetOk;
        if (cmdValid) begin
          if (cmdReady) begin
            stb.loadCmd = 1'b1;
            nextState   = (cmdSize == '0) ? ST_SMALL_REQ : ST_FILL;
          end else begin
            nextState = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (wrEmpty) begin
          stb.clrBytes = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      ST_SMALL_REQ: begin
        addrReq = 1'b1;
        if (addrAck) nextState = ST_SMALL_PUSH;
      end
      ST_SMALL_PUSH: begin
        if (dataValid && !afStall) begin
          stb.pushUser = 1'b1;
          dataReady    = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      ST_FILL: begin
        if (!afStall) begin
          if (status.inUser) begin
            if (dataValid) begin
              stb.pushUser = 1'b1;
              dataReady    = 1'b1;
              if (status.lastBeat) nextState = ST_BURST_REQ;
            end
          end else begin
            stb.pushPad = 1'b1;
            if (status.lastBeat) nextState = ST_BURST_REQ;
          end
        end
      end
      ST_BURST_REQ: begin
        addrReq = 1'b1;
        if (addrAck) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign wrPush = stb.pushPad | stb.pushUser;

  AST_NO_PUSH_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !(wrPush && addrReq)); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    addrReq && !addrAck |=> addrReq); // R4

  AST_AF_STALL: assert property (@(posedge clk) disable iff (!rstN)
    afMode && wrAlmostFull |-> !wrPush); // R8

  AST_DRAIN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DRAIN |-> !wrPush && !cmdReady); // R7

  AST_SMALL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SMALL_PUSH |-> !addrReq && $past(state) != ST_IDLE); // R2

endmodule

// File: rtl/wseq_top.sv
module wseq_top
  import wseq_pkg::*;
#(
  parameter int AddrW       = 32,
  parameter int DataW       = 64,
  parameter int MaxSizeLog  = 5,
  parameter int BudgetBytes = 1024,
  localparam int BeatW      = MaxSizeLog + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                afMode,
  input  logic                cmdValid,
  output logic                cmdReady,
  input  logic [AddrW-1:0]    cmdAddr,
  input  logic [SIZE_W-1:0]   cmdSize,
  input  logic [BeatW-1:0]    cmdLen,
  input  logic                dataValid,
  output logic                dataReady,
  input  logic [DataW-1:0]    dataIn,
  input  logic [DataW/8-1:0]  dataBe,
  output logic                wrPush,
  output logic [DataW-1:0]    wrData,
  output logic [DataW/8-1:0]  wrBe,
  input  logic                wrEmpty,
  input  logic                wrAlmostFull,
  output logic                addrReq,
  output logic [AddrW-1:0]    addrOut,
  output logic [SIZE_W-1:0]   sizeOut,
  input  logic                addrAck
);

  seqStrobes_t stb;
  seqStatus_t  status;

  wseq_control u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .afMode       (afMode),
    .cmdValid     (cmdValid),
    .cmdSize      (cmdSize),
    .dataValid    (dataValid),
    .wrAlmostFull (wrAlmostFull),
    .wrEmpty      (wrEmpty),
    .addrAck      (addrAck),
    .status       (status),
    .stb          (stb),
    .cmdReady     (cmdReady),
    .dataReady    (dataReady),
    .wrPush       (wrPush),
    .addrReq      (addrReq)
  );

  wseq_datapath #(
    .AddrW       (AddrW),
    .DataW       (DataW),
    .MaxSizeLog  (MaxSizeLog),
    .BudgetBytes (BudgetBytes)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .afMode  (afMode),
    .stb     (stb),
    .cmdAddr (cmdAddr),
    .cmdSize (cmdSize),
    .cmdLen  (cmdLen),
    .dataIn  (dataIn),
    .dataBe  (dataBe),
    .addrReq (addrReq),
    .status  (status),
    .wrData  (wrData),
    .wrBe    (wrBe),
    .addrOut (addrOut),
    .sizeOut (sizeOut)
  );

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    addrReq && !addrAck |=> $stable(addrOut) && $stable(sizeOut)); // R4

endmodule

// File: tb/tb_wseq_top.sv
module tb_wseq_top;

  localparam int ClkPeriod = 10;
  localparam int LogN = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        afMode = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [31:0] cmdAddr = '0;
  logic [2:0]  cmdSize = '0;
  logic [5:0]  cmdLen = '0;
  logic        dataValid = 1'b1;
  logic        dataReady;
  logic [63:0] dataIn;
  logic [7:0]  dataBe = 8'hFF;
  logic        wrPush;
  logic [63:0] wrData;
  logic [7:0]  wrBe;
  logic        wrEmpty = 1'b0;
  logic        wrAlmostFull = 1'b0;
  logic        addrReq;
  logic [31:0] addrOut;
  logic [2:0]  sizeOut;
  logic        addrAck;

  wseq_top dut (
    .clk(clk), .rstN(rstN), .afMode(afMode),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdAddr(cmdAddr),
    .cmdSize(cmdSize), .cmdLen(cmdLen),
    .dataValid(dataValid), .dataReady(dataReady), .dataIn(dataIn), .dataBe(dataBe),
    .wrPush(wrPush), .wrData(wrData), .wrBe(wrBe),
    .wrEmpty(wrEmpty), .wrAlmostFull(wrAlmostFull),
    .addrReq(addrReq), .addrOut(addrOut), .sizeOut(sizeOut), .addrAck(addrAck)
  );

  always #(ClkPeriod / 2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // controller acknowledge model
  int ackLat = 0;
  int reqAge = 0;
  always @(posedge clk) reqAge <= (addrReq && !addrAck) ? reqAge + 1 : 0;
  assign addrAck = addrReq && (reqAge >= ackLat);

  // port monitor, sampled on the falling edge
  logic [7:0]  vecTag = '0;
  int totPush = 0, totUser = 0, totReq = 0, accCnt = 0, holdErr = 0;
  logic        padLog  [LogN];
  logic [63:0] wordLog [LogN];
  logic [7:0]  beLog   [LogN];
  int          pushCyc [LogN];
  logic [31:0] reqAddrLog [64];
  logic [2:0]  reqSizeLog [64];
  int          reqPushLog [64];
  int          reqCycLog  [64];
  logic        prevReq = 1'b0, prevAck = 1'b0;
  logic [31:0] prevAddr = '0;
  logic [2:0]  prevSize = '0;

  assign dataIn = {16'hA5A5, vecTag, 8'h00, 32'(totUser)};

  always @(negedge clk) begin
    if (rstN) begin
      if (prevReq && !prevAck && (!addrReq || addrOut != prevAddr || sizeOut != prevSize))
        holdErr++;
      prevReq = addrReq; prevAck = addrAck; prevAddr = addrOut; prevSize = sizeOut;
      if (cmdValid && cmdReady) accCnt++;
      if (addrReq && addrAck && totReq < 64) begin
        reqAddrLog[totReq] = addrOut;
        reqSizeLog[totReq] = sizeOut;
        reqPushLog[totReq] = totPush;
        reqCycLog[totReq]  = cyc;
        totReq++;
      end
      if (wrPush && totPush < LogN) begin
        padLog[totPush]  = (wrBe == 8'h00);
        pushCyc[totPush] = cyc;
        if (wrBe != 8'h00 && totUser < LogN) begin
          wordLog[totUser] = wrData;
          beLog[totUser]   = wrBe;
          totUser++;
        end
        totPush++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  size;
    logic [5:0]  len;
    logic [7:0]  be;
    logic [31:0] expAddr;
    logic [5:0]  expLead;
    logic [6:0]  expBeats;
  } vec_t;

  localparam int NVec = 9;
  localparam vec_t VecTab [NVec] = '{
    '{32'h0000_1000, 3'd0, 6'd1,  8'h01, 32'h0000_1000, 6'd0,  7'd1},
    '{32'h0000_2004, 3'd0, 6'd1,  8'h30, 32'h0000_2000, 6'd0,  7'd1},
    '{32'h0000_3000, 3'd2, 6'd4,  8'hFF, 32'h0000_3000, 6'd0,  7'd4},
    '{32'h0000_3048, 3'd2, 6'd3,  8'hFF, 32'h0000_3040, 6'd1,  7'd4},
    '{32'h0000_4010, 3'd3, 6'd3,  8'hFF, 32'h0000_4000, 6'd2,  7'd8},
    '{32'h0000_5000, 3'd5, 6'd32, 8'hFF, 32'h0000_5000, 6'd0,  7'd32},
    '{32'h0000_50F8, 3'd5, 6'd1,  8'hFF, 32'h0000_5000, 6'd31, 7'd32},
    '{32'h0000_6008, 3'd1, 6'd1,  8'hFF, 32'h0000_6000, 6'd1,  7'd2},
    '{32'h0000_7006, 3'd0, 6'd1,  8'h40, 32'h0000_7000, 6'd0,  7'd1}
  };

  task automatic runVec(input vec_t v, input logic [7:0] tag, input int stallDrain, input int stallAf);
    int basePush, baseUser, baseReq, baseAcc, t, padErr, wordErr;
    @(posedge clk); #1;
    vecTag = tag; cmdAddr = v.addr; cmdSize = v.size; cmdLen = v.len; dataBe = v.be;
    ackLat = int'(tag) % 3;
    basePush = totPush; baseUser = totUser; baseReq = totReq; baseAcc = accCnt;
    cmdValid = 1'b1;
    if (stallDrain > 0) begin
      repeat (stallDrain) @(posedge clk);
      // R7: over budget, nothing accepted or pushed until empty is seen
      chk(accCnt == baseAcc && totPush == basePush, "R7 held off while over budget",
          longint'(totPush - basePush), 0);
      #1 wrEmpty = 1'b1;
    end
    t = 0;
    while (accCnt == baseAcc && t < 500) begin @(posedge clk); t++; end
    #1; cmdValid = 1'b0; wrEmpty = 1'b0;
    chk(accCnt == baseAcc + 1, "R9 command accepted", longint'(accCnt - baseAcc), 1);
    if (stallAf > 0) begin
      repeat (stallAf) @(posedge clk);
      chk(totPush == basePush, "R8 no push while almost full", longint'(totPush - basePush), 0);
      #1 wrAlmostFull = 1'b0;
    end
    t = 0;
    while ((totReq == baseReq || totPush < basePush + int'(v.expBeats)) && t < 500) begin
      @(posedge clk); t++;
    end
    repeat (3) @(posedge clk);
    chk(totPush - basePush == int'(v.expBeats), "R6 beats pushed",
        longint'(totPush - basePush), longint'(v.expBeats));
    chk(totReq - baseReq == 1, "R3 one request", longint'(totReq - baseReq), 1);
    chk(reqAddrLog[baseReq] == v.expAddr, "R5 aligned address",
        longint'(reqAddrLog[baseReq]), longint'(v.expAddr));
    chk(reqSizeLog[baseReq] == v.size, "R5 size code",
        longint'(reqSizeLog[baseReq]), longint'(v.size));
    if (v.size != 3'd0) begin
      padErr = 0;
      for (int k = 0; k < int'(v.expBeats); k++) begin
        if (padLog[basePush + k] != ((k < int'(v.expLead)) || (k >= int'(v.expLead) + int'(v.len))))
          padErr++;
      end
      chk(padErr == 0, "R6 pad placement", longint'(padErr), 0);
      chk(reqPushLog[baseReq] == basePush + int'(v.expBeats), "R1 fill before request",
          longint'(reqPushLog[baseReq] - basePush), longint'(v.expBeats));
    end else begin
      chk(reqPushLog[baseReq] == basePush, "R3 small request after earlier pushes",
          longint'(reqPushLog[baseReq]), longint'(basePush));
      chk(pushCyc[basePush] > reqCycLog[baseReq], "R2 push after acknowledge",
          longint'(pushCyc[basePush]), longint'(reqCycLog[baseReq] + 1));
      chk(beLog[baseUser] == v.be, "R2 byte enables", longint'(beLog[baseUser]), longint'(v.be));
    end
    wordErr = 0;
    for (int k = 0; k < int'(v.len); k++) begin
      if (wordLog[baseUser + k] != {16'hA5A5, tag, 8'h00, 32'(baseUser + k)}) wordErr++;
    end
    chk(totUser - baseUser == int'(v.len) && wordErr == 0, "R10 user data order",
        longint'(wordErr), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(addrReq == 1'b0, "R9 request low after reset", longint'(addrReq), 0);
    chk(wrPush == 1'b0, "R9 push low after reset", longint'(wrPush), 0);
    chk(cmdReady == 1'b1, "R9 ready after reset", longint'(cmdReady), 1);

    for (int i = 0; i < NVec; i++) runVec(VecTab[i], 8'(i), 0, 0);

    // budget now 680 bytes; this 256-byte burst still fits (936)
    runVec('{32'h0000_A0C0, 3'd5, 6'd8, 8'hFF, 32'h0000_A000, 6'd24, 7'd32}, 8'd20, 0, 0);

    // R8: almost-full mode, accepted despite budget, stalls while almost full
    @(posedge clk); #1 afMode = 1'b1; wrAlmostFull = 1'b1;
    runVec('{32'h0000_B000, 3'd5, 6'd32, 8'hFF, 32'h0000_B000, 6'd0, 7'd32}, 8'd21, 0, 12);
    @(posedge clk); #1 afMode = 1'b0;

    // R7: budget mode over limit, waits for empty flag then proceeds
    runVec('{32'h0000_C000, 3'd5, 6'd32, 8'hFF, 32'h0000_C000, 6'd0, 7'd32}, 8'd22, 20, 0);

    chk(holdErr == 0, "R4 request held stable until acknowledge", longint'(holdErr), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule